// File: doc/BRIEF.md
# Two-Bank I2C Byte Memory Target

This block is an I2C target that holds 512 bytes of read/write storage. It uses register-style transfers. A controller first sends one 8-bit word pointer. It then streams data bytes in, or reads them back, and the pointer steps by one after each byte. The storage is split into two banks of 256 bytes. The target answers on two neighbouring 7-bit device addresses, and bit 0 of the 7-bit address picks the bank.

The pointer is kept across STOP and repeated START. A controller can therefore set it with a write that carries no data, and read from that location in a later transaction. The bus is sampled with a fast system clock. SCL is input only, because the target never stretches the clock. SDA is handled as an open-drain pin, with a pull-low enable output. Timing for non-volatile writes and page limits is not modelled. Writes take effect immediately.

Top module: `i2cbank_target`

## Requirements
- R1: After reset, SDA is released, every byte of storage reads 0x00, the pointer is 0 and bank 0 is selected.
- R2: An address byte carries the 7-bit device address in bits 7..1 and the direction in bit 0 (0 = write, 1 = read). Device addresses 0x50 and 0x51 are acknowledged by pulling SDA low during the ninth clock.
- R3: Any other device address is not acknowledged. The target keeps SDA released until the next START.
- R4: In a write transaction, the first byte after the address byte loads the word pointer and is acknowledged.
- R5: Each later byte of a write transaction is acknowledged and stored at {bank, pointer}. The pointer then steps by one.
- R6: The pointer wraps from 0xFF to 0x00 inside the current bank. The bank does not change.
- R7: Address 0x50 reaches bytes 0–255 and address 0x51 reaches bytes 256–511. The bank follows the most recently acknowledged device address, while the pointer is kept.
- R8: The pointer survives both STOP and repeated START. A pointer-only write followed by a read, in the same or a later transaction, returns the byte at that pointer.
- R9: In a read, the target shifts data out MSB first and changes SDA only while SCL is low. The pointer steps after every byte sent. A controller ACK (SDA low) makes the target send the next sequential byte.
- R10: After a controller NACK (SDA high), the target releases SDA and drives nothing until a START. STOP returns it to idle.
- R11: A START at any point restarts address reception, and a STOP at any point returns to idle. A partly received byte is discarded and is not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |

## Verification
The bench targets these corner cases:

- **Bank decode.** The bench writes the same pointer in both banks with different data. A target that ignored the low address bit would return the later write for both banks.
- **Wrap.** A sequential write runs across 0xFF and is read back. A design that carried the wrap into the bank bit would corrupt bank 0 byte 0.
- **Pointer persistence.** A pointer is set in one transaction and read in another, and a bank switch happens with no new pointer. A design that cleared the pointer on STOP, or reloaded it on address, would return the wrong byte.
- **Aborted bytes.** A START or STOP cuts into a byte. A design that stored partial bytes, or missed the START, would corrupt memory or fail to acknowledge the address that follows.
- **Bus release.** After a NACK or an unmatched address, the bench clocks the bus further. A target that still drove SDA would show up as a low level.

// File: rtl/i2cbank_pkg.sv
package i2cbank_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_TXACK
    } tgt_state_e;

    typedef enum logic [1:0] {
        K_ADDR,
        K_PTR,
        K_DATA
    } rx_kind_e;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/i2cbank_sync.sv
module i2cbank_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic [STAGES-1:0] scl_meta;
        logic [STAGES-1:0] sda_meta;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.scl_meta = {s_q.scl_meta[STAGES-2:0], scl_i};
        s_d.sda_meta = {s_q.sda_meta[STAGES-2:0], sda_i};
        s_d.scl_prev = s_q.scl_meta[STAGES-1];
        s_d.sda_prev = s_q.sda_meta[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign scl_o      = s_q.scl_meta[STAGES-1];
    assign sda_o      = s_q.sda_meta[STAGES-1];
    assign scl_rise_o = scl_o & ~s_q.scl_prev;
    assign scl_fall_o = ~scl_o & s_q.scl_prev;
    // SDA moving while SCL stays high marks START (falling) or STOP (rising).
    assign start_o    = scl_o & s_q.scl_prev & ~sda_o & s_q.sda_prev;
    assign stop_o     = scl_o & s_q.scl_prev & sda_o & ~s_q.sda_prev;

endmodule

// File: rtl/i2cbank_store.sv
module i2cbank_store #(
    parameter int unsigned AW = 9,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we_i) begin
            mem_d[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata_o = mem_q[raddr_i];

    // R5
    store_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));

endmodule

// File: rtl/i2cbank_target.sv
module i2cbank_target #(
    parameter logic [6:0]  BASE_ADDR = 7'h50,
    parameter int unsigned BANK_BITS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o
);
    import i2cbank_pkg::*;

    localparam int unsigned PTR_W = BYTE_W;
    localparam int unsigned AW    = BANK_BITS + PTR_W;
    localparam int unsigned CNT_W = 4;

    typedef struct packed {
        tgt_state_e           state;
        rx_kind_e             kind;
        logic [CNT_W-1:0]     cnt;
        logic [BYTE_W-1:0]    shift;
        logic [BANK_BITS-1:0] bank;
        logic [PTR_W-1:0]     ptr;
        logic                 rw;
        logic                 nack;
        logic                 oe;
    } tgt_t;

    tgt_t r_d, r_q;

    logic scl_s, sda_s, scl_rise, scl_fall, start_w, stop_w;
    logic              we;
    logic [BYTE_W-1:0] rd_data;

    i2cbank_sync #(.STAGES(2)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_w),
        .stop_o     (stop_w)
    );

    i2cbank_store #(.AW(AW), .DW(BYTE_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we),
        .waddr_i ({r_q.bank, r_q.ptr}),
        .wdata_i (r_q.shift),
        .raddr_i ({r_q.bank, r_q.ptr}),
        .rdata_o (rd_data)
    );

    always_comb begin
        r_d = r_q;
        we  = 1'b0;
        if (stop_w) begin
            r_d.state = ST_IDLE;
            r_d.oe    = 1'b0;
        end else if (start_w) begin
            r_d.state = ST_RX;
            r_d.kind  = K_ADDR;
            r_d.cnt   = '0;
            r_d.oe    = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    r_d.oe = 1'b0;
                end
                ST_RX: begin
                    if (scl_rise && r_q.cnt != CNT_W'(8)) begin
                        r_d.shift = {r_q.shift[BYTE_W-2:0], sda_s};
                        r_d.cnt   = r_q.cnt + CNT_W'(1);
                    end else if (scl_fall && r_q.cnt == CNT_W'(8)) begin
                        r_d.state = ST_ACK;
                        r_d.oe    = 1'b1;
                        unique case (r_q.kind)
                            K_ADDR: begin
                                if (r_q.shift[7:BANK_BITS+1] == BASE_ADDR[6:BANK_BITS]) begin
                                    r_d.bank = r_q.shift[BANK_BITS:1];
                                    r_d.rw   = r_q.shift[0];
                                end else begin
                                    r_d.state = ST_IDLE;
                                    r_d.oe    = 1'b0;
                                end
                            end
                            K_PTR: begin
                                r_d.ptr = r_q.shift;
                            end
                            default: begin
                                we      = 1'b1;
                                r_d.ptr = r_q.ptr + PTR_W'(1);
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        r_d.cnt = '0;
                        if (r_q.kind == K_ADDR && r_q.rw) begin
                            r_d.state = ST_TX;
                            r_d.shift = rd_data;
                            r_d.oe    = ~rd_data[BYTE_W-1];
                        end else begin
                            r_d.state = ST_RX;
                            r_d.oe    = 1'b0;
                            r_d.kind  = (r_q.kind == K_ADDR) ? K_PTR : K_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (r_q.cnt == CNT_W'(7)) begin
                            r_d.state = ST_TXACK;
                            r_d.oe    = 1'b0;
                            r_d.cnt   = '0;
                            r_d.ptr   = r_q.ptr + PTR_W'(1);
                        end else begin
                            r_d.shift = {r_q.shift[BYTE_W-2:0], 1'b0};
                            r_d.oe    = ~r_q.shift[BYTE_W-2];
                            r_d.cnt   = r_q.cnt + CNT_W'(1);
                        end
                    end
                end
                ST_TXACK: begin
                    if (scl_rise) begin
                        r_d.nack = sda_s;
                    end else if (scl_fall) begin
                        if (r_q.nack) begin
                            r_d.state = ST_IDLE;
                            r_d.oe    = 1'b0;
                        end else begin
                            r_d.state = ST_TX;
                            r_d.cnt   = '0;
                            r_d.shift = rd_data;
                            r_d.oe    = ~rd_data[BYTE_W-1];
                        end
                    end
                end
                default: begin
                    r_d.state = ST_IDLE;
                    r_d.oe    = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.kind  <= K_ADDR;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe_o = r_q.oe;

    // R3
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE) |-> !sda_oe_o);

    // R11
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_w |=> (r_q.state == ST_IDLE && !sda_oe_o));

    // R11
    start_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_w |=> (r_q.state == ST_RX && r_q.kind == K_ADDR && r_q.cnt == '0));

    // R9
    drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_s);

    // R8
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !scl_fall |=> $stable(r_q.ptr));

endmodule

// File: tb/i2cbank_target_tb.sv
module i2cbank_target_tb;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam logic [6:0] A0 = 7'h50;
    localparam logic [6:0] A1 = 7'h51;

    // {device address, pointer, data}
    localparam logic [22:0] VEC [8] = '{
        {7'h50, 8'h00, 8'hA5}, {7'h51, 8'h00, 8'h5A},
        {7'h50, 8'h7F, 8'h3C}, {7'h51, 8'h7F, 8'hC3},
        {7'h50, 8'hFF, 8'h81}, {7'h51, 8'h10, 8'h0F},
        {7'h50, 8'h10, 8'hF0}, {7'h51, 8'h80, 8'h66}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic sda_oe;
    logic sda_bus;
    logic seen_drive;
    bit   done = 0;
    int   n_chk = 0;
    int   n_bad = 0;

    assign sda_bus = sda_drv & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2cbank_target u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_drv),
        .sda_i    (sda_bus),
        .sda_oe_o (sda_oe)
    );

    always @(negedge clk) if (sda_oe) seen_drive <= 1'b1;

    task automatic wq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; wq(1);
        scl_drv = 1'b1; wq(1);
        sda_drv = 1'b0; wq(1);
        scl_drv = 1'b0; wq(1);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wq(1);
        scl_drv = 1'b1; wq(1);
        sda_drv = 1'b1; wq(2);
    endtask

    task automatic bit_out(input logic b);
        sda_drv = b;    wq(1);
        scl_drv = 1'b1; wq(2);
        scl_drv = 1'b0; wq(1);
    endtask

    task automatic bit_in(output logic b);
        sda_drv = 1'b1; wq(1);
        scl_drv = 1'b1; wq(1);
        b = sda_bus;    wq(1);
        scl_drv = 1'b0; wq(1);
    endtask

    task automatic tx(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(b);
        ack = ~b;
    endtask

    task automatic rx(output logic [7:0] v, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            v[i] = b;
        end
        bit_out(~give_ack);
    endtask

    task automatic set_ptr(input logic [6:0] a, input logic [7:0] p, input string tag);
        logic ack;
        bus_start();
        tx({a, 1'b0}, ack); check({tag, " addr ack"}, {7'd0, ack}, 8'd1);
        tx(p, ack);         check({tag, " ptr ack"}, {7'd0, ack}, 8'd1);
    endtask

    task automatic rd1(input logic [6:0] a, input logic [7:0] exp, input string tag);
        logic ack;
        logic [7:0] v;
        bus_start();
        tx({a, 1'b1}, ack); check({tag, " read addr ack"}, {7'd0, ack}, 8'd1);
        rx(v, 1'b0);        check({tag, " data"}, v, exp);
        bus_stop();
    endtask

    initial begin
        logic ack;
        logic b;
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: released after reset; current read at pointer 0 of bank 0 gives zero
        check("R1 sda released", {7'd0, sda_oe}, 8'd0);
        rd1(A0, 8'h00, "R1 reset content");

        // R2 R4 R5 R7: table of single-byte writes, then random reads with repeated START
        for (int i = 0; i < 8; i++) begin
            set_ptr(VEC[i][22:16], VEC[i][15:8], "R2 R4 write");
            tx(VEC[i][7:0], ack); check("R5 data ack", {7'd0, ack}, 8'd1);
            bus_stop();
        end
        for (int i = 0; i < 8; i++) begin
            set_ptr(VEC[i][22:16], VEC[i][15:8], "R8 ptr");
            rd1(VEC[i][22:16], VEC[i][7:0], "R7 bank readback");
        end

        // R3: unmatched addresses get no ACK and the target stays off the bus
        seen_drive = 1'b0;
        bus_start();
        tx({7'h52, 1'b0}, ack); check("R3 no ack 0x52", {7'd0, ack}, 8'd0);
        tx(8'h00, ack);         check("R3 later byte", {7'd0, ack}, 8'd0);
        bus_start();
        tx({7'h28, 1'b1}, ack); check("R3 no ack 0x28", {7'd0, ack}, 8'd0);
        bit_in(b);              check("R3 bus high", {7'd0, b}, 8'd1);
        bus_stop();
        check("R3 never drove", {7'd0, seen_drive}, 8'd0);

        // R6: sequential write across the top of bank 1, read back sequentially
        set_ptr(A1, 8'hFE, "R6");
        tx(8'h11, ack); check("R6 ack0", {7'd0, ack}, 8'd1);
        tx(8'h22, ack); check("R6 ack1", {7'd0, ack}, 8'd1);
        tx(8'h33, ack); check("R6 ack2", {7'd0, ack}, 8'd1);
        bus_stop();
        set_ptr(A1, 8'hFE, "R6 rd");
        bus_start();
        tx({A1, 1'b1}, ack); check("R6 rd addr", {7'd0, ack}, 8'd1);
        rx(v, 1'b1); check("R9 R6 byte FE", v, 8'h11);
        rx(v, 1'b1); check("R9 R6 byte FF", v, 8'h22);
        rx(v, 1'b0); check("R6 wrap byte 00", v, 8'h33);
        bus_stop();
        set_ptr(A0, 8'h00, "R6 bank0");
        bus_stop();
        rd1(A0, 8'hA5, "R6 bank0 untouched");

        // R8: pointer-only write, STOP, later read; then current read continues
        set_ptr(A1, 8'h7F, "R8");
        bus_stop();
        rd1(A1, 8'hC3, "R8 after stop");
        rd1(A1, 8'h66, "R9 pointer advanced");
        // R7: bank follows the newly acknowledged address, pointer kept
        set_ptr(A1, 8'h10, "R7");
        bus_stop();
        rd1(A0, 8'hF0, "R7 bank switch");

        // R10: after NACK the target lets go, even while SCL keeps toggling
        set_ptr(A0, 8'h00, "R10");
        bus_start();
        tx({A0, 1'b1}, ack);
        rx(v, 1'b0); check("R10 data", v, 8'hA5);
        seen_drive = 1'b0;
        bit_in(b); check("R10 released", {7'd0, b}, 8'd1);
        for (int i = 0; i < 7; i++) bit_in(b);
        check("R10 no drive", {7'd0, seen_drive}, 8'd0);
        bus_stop();

        // R11: START inside a byte restarts addressing; STOP inside a byte stores nothing
        bus_start();
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
        set_ptr(A0, 8'h20, "R11 restart");
        tx(8'h77, ack); check("R11 data ack", {7'd0, ack}, 8'd1);
        bit_out(1'b1); bit_out(1'b1); bit_out(1'b1);
        bus_stop();
        set_ptr(A0, 8'h21, "R11 rd");
        rd1(A0, 8'h00, "R11 partial dropped");
        set_ptr(A0, 8'h20, "R11 rd2");
        rd1(A0, 8'h77, "R11 full byte kept");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule